// File: doc/BRIEF.md
# Serial Controller Interrupt Identification

This block decides which interrupt a 16550-style serial controller reports and drives the controller's single interrupt request line. It takes the stored four-bit enable register, the line status byte, the receive FIFO fill count and trigger level, the FIFO enable, a character-timeout flag, and the four modem-status change bits. From these it picks the highest-priority active source and registers an 8-bit identification byte and a level interrupt request.

The block also owns the sticky "transmit holding empty" pending flag. Writes of a transmit byte, transmit FIFO resets, writes to the enable register and reads of the identification byte update this flag. Serialisation, baud generation and the FIFO storage sit elsewhere and reach this block only through the status pins. All inputs are plain control and status levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: When several sources are active, the one reported follows this fixed order, highest first: line error, character timeout, receive data, transmit empty, modem change.
- R2: Bits 3:0 of `ident_byte` carry the code. The codes are 0x6 for line error, 0xC for timeout, 0x4 for receive data, 0x2 for transmit empty and 0x0 for modem change. 0x1 means no source is active. Bits 5:4 always read 0.
- R3: A line error is active when enable bit 2 is set and any `line_stat` bit under mask 0x1E is set. Those bits are overrun (1), parity (2), framing (3) and break (4). `line_stat` bit 0 is data ready and bit 5 is holding register empty.
- R4: The character timeout is active only when `timeout_pend` is high and enable bit 0 is set. No other bit can enable it.
- R5: Receive data is active when enable bit 0 is set and data ready is set. When `fifo_on` is high it also needs `rx_count` >= `rx_trig`.
- R6: An `ident_read` clears the transmit-empty pending flag only while `ident_byte[3:0]` is 0x2. A read that shows any other code leaves the flag unchanged.
- R7: An enable-register write that flips bit 1 sets the pending flag if the new bit 1 is 1 and `line_stat` bit 5 is 1. Otherwise such a write clears the flag. A write that leaves bit 1 unchanged does not touch the flag. The transmit-empty source is active when enable bit 1 and the flag are both set.
- R8: `thr_write` clears the pending flag and `tx_fifo_reset` sets it. If both arrive in the same cycle, the clear wins. Either strobe takes precedence over an enable write or an identification read in that cycle.
- R9: `ident_byte[7:6]` reads 2'b11 while `fifo_on` is high and 2'b00 otherwise. Only the low four bits of an enable write are stored, and the stored value is visible on `ier_q`.
- R10: `irq` is a registered level, high exactly when the registered code differs from 0x1. `irq` and `ident_byte` follow a change on a status input one clock edge later. They follow a pending-flag or enable-write event two edges later.
- R11: During reset `ier_q` is 0, the pending flag is 0, `ident_byte` is 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ier_wr | input | 1 | Strobe: write `ier_wdata` to the enable register |
| ier_wdata | input | 8 | Enable write data; only bits 3:0 are kept |
| ier_q | output | 4 | Stored enable bits: 0 receive/timeout, 1 transmit empty, 2 line error, 3 modem |
| line_stat | input | 8 | Line status byte (bit 0 data ready, bits 4:1 errors, bit 5 holding empty) |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| fifo_on | input | 1 | FIFO mode enabled |
| timeout_pend | input | 1 | Character timeout has expired |
| modem_delta | input | 4 | Modem status change bits |
| thr_write | input | 1 | Strobe: a transmit byte was written |
| tx_fifo_reset | input | 1 | Strobe: the transmit FIFO was reset |
| ident_read | input | 1 | Strobe: the identification byte is being read |
| ident_byte | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request level |

## Verification
The hardest case to reach is a read of the identification byte while the transmit-empty flag is set but hidden behind a higher-priority line error. The read must leave the flag alone, and only a later status change can show that it survived. The stimulus first sets the flag by flipping enable bit 1 while the holding register is empty. It then raises an overrun bit and reads the identification byte. After that it removes the error and expects code 0x2 to come back. Same-cycle collisions of the transmit strobes, and enable rewrites that do not flip bit 1, are driven as directed steps after the vector table.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // Source slots, index 0 is the highest priority
  localparam int NUM_SRC   = 5;
  localparam int SRC_LINE  = 0;
  localparam int SRC_TMO   = 1;
  localparam int SRC_RXD   = 2;
  localparam int SRC_THRE  = 3;
  localparam int SRC_MODEM = 4;

  // Enable register bit positions
  localparam int IER_W       = 4;
  localparam int EN_RX_BIT   = 0;
  localparam int EN_THRE_BIT = 1;
  localparam int EN_LINE_BIT = 2;
  localparam int EN_MODEM_BIT = 3;

  // Line status positions
  localparam logic [7:0] LSR_ERR_MASK = 8'h1E;
  localparam int LSR_DR_BIT   = 0;
  localparam int LSR_THRE_BIT = 5;

  function automatic irq_id_e src_code(input int idx);
    case (idx)
      SRC_LINE:  return ID_LINE;
      SRC_TMO:   return ID_TIMEOUT;
      SRC_RXD:   return ID_RXDATA;
      SRC_THRE:  return ID_THRE;
      default:   return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int WDATA_W = 8,
  parameter int KEEP_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [WDATA_W-1:0] wdata,
  output logic [KEEP_W-1:0]  en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata[KEEP_W-1:0];
  end
endmodule

// File: rtl/uart_thre_pending.sv
module uart_thre_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_new,
  input  logic en_old,
  input  logic holding_empty,
  input  logic thr_write,
  input  logic tx_fifo_reset,
  input  logic ident_read,
  input  logic ident_is_thre,
  output logic pend_q
);
  logic en_flip;
  assign en_flip = en_wr && (en_new != en_old);

  always_ff @(posedge clk) begin
    if (!rst_n)                          pend_q <= 1'b0;
    else if (thr_write)                  pend_q <= 1'b0;
    else if (tx_fifo_reset)              pend_q <= 1'b1;
    else if (en_flip)                    pend_q <= en_new && holding_empty;
    else if (ident_read && ident_is_thre) pend_q <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_src_decode.sv
module uart_irq_src_decode
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [IER_W-1:0]   en,
  input  logic [7:0]         line_stat,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic               fifo_on,
  input  logic               timeout_pend,
  input  logic               thre_pend,
  input  logic [3:0]         modem_delta,
  output logic [NUM_SRC-1:0] req
);
  logic level_met;
  assign level_met = !fifo_on || (rx_count >= rx_trig);

  always_comb begin
    req            = '0;
    req[SRC_LINE]  = en[EN_LINE_BIT] && |(line_stat & LSR_ERR_MASK);
    req[SRC_TMO]   = en[EN_RX_BIT] && timeout_pend;
    req[SRC_RXD]   = en[EN_RX_BIT] && line_stat[LSR_DR_BIT] && level_met;
    req[SRC_THRE]  = en[EN_THRE_BIT] && thre_pend;
    req[SRC_MODEM] = en[EN_MODEM_BIT] && |modem_delta;
  end
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output irq_id_e            code
);
  // Walk from lowest to highest priority so the highest one overwrites
  always_comb begin
    code = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int RX_DEPTH = 16,
  localparam int CNT_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [IER_W-1:0] ier_q,
  input  logic [7:0]       line_stat,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             fifo_on,
  input  logic             timeout_pend,
  input  logic [3:0]       modem_delta,
  input  logic             thr_write,
  input  logic             tx_fifo_reset,
  input  logic             ident_read,
  output logic [7:0]       ident_byte,
  output logic             irq
);
  logic               thre_pend;
  logic [NUM_SRC-1:0] req;
  irq_id_e            code;
  logic [7:0]         ident_q;
  logic               irq_q;

  uart_irq_enable_reg #(.WDATA_W(8), .KEEP_W(IER_W)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ier_wr),
    .wdata (ier_wdata),
    .en_q  (ier_q)
  );

  uart_thre_pending u_pend (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_wr         (ier_wr),
    .en_new        (ier_wdata[EN_THRE_BIT]),
    .en_old        (ier_q[EN_THRE_BIT]),
    .holding_empty (line_stat[LSR_THRE_BIT]),
    .thr_write     (thr_write),
    .tx_fifo_reset (tx_fifo_reset),
    .ident_read    (ident_read),
    .ident_is_thre (ident_q[3:0] == ID_THRE),
    .pend_q        (thre_pend)
  );

  uart_irq_src_decode #(.CNT_W(CNT_W)) u_dec (
    .en           (ier_q),
    .line_stat    (line_stat),
    .rx_count     (rx_count),
    .rx_trig      (rx_trig),
    .fifo_on      (fifo_on),
    .timeout_pend (timeout_pend),
    .thre_pend    (thre_pend),
    .modem_delta  (modem_delta),
    .req          (req)
  );

  uart_irq_prio_enc u_enc (
    .req  (req),
    .code (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ident_q <= {4'h0, ID_NONE};
      irq_q   <= 1'b0;
    end else begin
      ident_q <= {{2{fifo_on}}, 2'b00, code};
      irq_q   <= (code != ID_NONE);
    end
  end

  assign ident_byte = ident_q;
  assign irq        = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ier_wr,
  input logic [7:0]       ier_wdata,
  input logic [3:0]       ier_q,
  input logic [7:0]       line_stat,
  input logic             fifo_on,
  input logic             thr_write,
  input logic [7:0]       ident_byte,
  input logic             irq
);
  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && |(line_stat & 8'h1E)) |=> ident_byte[3:0] == 4'h6); // R1
  AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_q[0] |=> ident_byte[3:0] != 4'hC); // R4
  AST_FIFO_TAG_ON: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on |=> ident_byte[7:6] == 2'b11); // R9
  AST_FIFO_TAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> ident_byte[7:6] == 2'b00); // R9
  AST_EN_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_q == $past(ier_wdata[3:0])); // R9
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 4'h0) |=> !irq); // R10
  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |-> ##2 (ident_byte[3:0] != 4'h2)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ident_byte[5:4] == 2'b00); // R2
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ier_wr     (ier_wr),
  .ier_wdata  (ier_wdata),
  .ier_q      (ier_q),
  .line_stat  (line_stat),
  .fifo_on    (fifo_on),
  .thr_write  (thr_write),
  .ident_byte (ident_byte),
  .irq        (irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  localparam int RX_DEPTH = 16;
  localparam int CNT_W    = $clog2(RX_DEPTH + 1);
  localparam int NVEC     = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ier_wr = 1'b0;
  logic [7:0]       ier_wdata = '0;
  logic [3:0]       ier_q;
  logic [7:0]       line_stat = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] rx_trig = '0;
  logic             fifo_on = 1'b0;
  logic             timeout_pend = 1'b0;
  logic [3:0]       modem_delta = '0;
  logic             thr_write = 1'b0;
  logic             tx_fifo_reset = 1'b0;
  logic             ident_read = 1'b0;
  logic [7:0]       ident_byte;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident #(.RX_DEPTH(RX_DEPTH)) dut (.*);

  // {enable, line_stat, count, trigger, fifo, timeout, modem, expected ident}
  localparam logic [35:0] VECS [NVEC] = '{
    {4'h0, 8'h1E, 5'd0,  5'd1,  1'b0, 1'b1, 4'hF, 8'h01}, // R3 R4 all masked
    {4'hF, 8'h03, 5'd0,  5'd1,  1'b0, 1'b1, 4'hF, 8'h06}, // R1 line over all
    {4'hF, 8'h01, 5'd2,  5'd4,  1'b1, 1'b1, 4'hF, 8'hCC}, // R1 timeout next
    {4'hF, 8'h01, 5'd2,  5'd4,  1'b1, 1'b0, 4'hF, 8'hC0}, // R5 below trigger
    {4'hF, 8'h01, 5'd4,  5'd4,  1'b1, 1'b0, 4'hF, 8'hC4}, // R5 at trigger
    {4'hF, 8'h01, 5'd0,  5'd8,  1'b0, 1'b0, 4'hF, 8'h04}, // R5 fifo off
    {4'hB, 8'h10, 5'd0,  5'd1,  1'b0, 1'b0, 4'h0, 8'h01}, // R3 break masked
    {4'hA, 8'h01, 5'd0,  5'd1,  1'b0, 1'b1, 4'h1, 8'h00}, // R4 timeout masked
    {4'h4, 8'h08, 5'd0,  5'd1,  1'b1, 1'b0, 4'h0, 8'hC6}, // R3 framing
    {4'h1, 8'h01, 5'd15, 5'd14, 1'b1, 1'b0, 4'h0, 8'hC4}, // R5 above trigger
    {4'h1, 8'h00, 5'd5,  5'd1,  1'b1, 1'b0, 4'h0, 8'hC1}, // R5 no data ready
    {4'h8, 8'h00, 5'd0,  5'd1,  1'b0, 1'b0, 4'h0, 8'h01}  // R2 none
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    ier_wr = 1'b0; thr_write = 1'b0; tx_fifo_reset = 1'b0; ident_read = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v);
    ier_wdata = v; ier_wr = 1'b1;
    settle();
  endtask

  task automatic see(input string tag, input logic [7:0] exp);
    chk(tag, ident_byte, exp);
    chk(tag, {7'h0, irq}, {7'h0, exp[3:0] != 4'h1});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    see("R11 reset ident", 8'h01);
    chk("R11 reset enable", {4'h0, ier_q}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      {ier_wdata[3:0], line_stat, rx_count, rx_trig, fifo_on, timeout_pend, modem_delta} = VECS[i][35:8];
      ier_wdata[7:4] = 4'h0;
      ier_wr = 1'b1;
      settle();
      see($sformatf("R1 R2 vector %0d", i), VECS[i][7:0]);
    end

    // R9 only low nibble stored
    line_stat = 8'h00; modem_delta = 4'h0; timeout_pend = 1'b0; fifo_on = 1'b0;
    wr_en(8'hFF);
    chk("R9 enable low nibble", {4'h0, ier_q}, 8'h0F);
    see("R2 idle with all enables", 8'h01);

    // R7 flip of bit 1 with holding empty sets the flag
    line_stat = 8'h20;
    wr_en(8'h00);
    wr_en(8'h02);
    see("R7 flip sets pending", 8'h02);
    wr_en(8'h02);
    see("R7 rewrite keeps pending", 8'h02);
    ident_read = 1'b1; settle();
    see("R6 read of code 2 clears", 8'h01);
    wr_en(8'h02);
    see("R7 rewrite does not set", 8'h01);

    // R8 transmit strobes
    tx_fifo_reset = 1'b1; settle();
    see("R8 fifo reset sets", 8'h02);
    thr_write = 1'b1; settle();
    see("R8 byte write clears", 8'h01);
    tx_fifo_reset = 1'b1; thr_write = 1'b1; settle();
    see("R8 clear wins same cycle", 8'h01);

    // R7 flip with holding not empty clears
    tx_fifo_reset = 1'b1; settle();
    line_stat = 8'h00;
    wr_en(8'h00);
    wr_en(8'h02);
    see("R7 flip without empty clears", 8'h01);

    // R6 read while transmit empty is hidden behind a line error
    tx_fifo_reset = 1'b1; settle();
    line_stat = 8'h22;
    wr_en(8'h06);
    see("R1 line hides transmit", 8'h06);
    ident_read = 1'b1; settle();
    line_stat = 8'h20;
    settle();
    see("R6 hidden read keeps pending", 8'h02);

    // R10 one-edge latency of a status change
    line_stat = 8'h00;
    wr_en(8'h04);
    see("R10 quiet", 8'h01);
    line_stat = 8'h02;
    #0.5;
    chk("R10 irq not combinational", {7'h0, irq}, 8'h00);
    @(negedge clk);
    see("R10 one edge later", 8'h06);

    // R11 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    see("R11 reset mid-run", 8'h01);
    chk("R11 reset clears enable", {4'h0, ier_q}, 8'h00);
    rst_n = 1'b1;
    line_stat = 8'h20;
    tx_fifo_reset = 1'b0;
    @(negedge clk);
    wr_en(8'h02);
    wr_en(8'h02);
    see("R11 flag restarts from zero", 8'h02);

    finish_run();
  end
endmodule